// File: doc/BRIEF.md
# Frame-Level Go-Back-N Retry Engine

This block gives one pair of bridge adapters reliable, in-order delivery of encapsulated frames across a Layer 2 network that can drop traffic through congestion or corrupt it with bit errors. Each sequence number stands for one whole encapsulated frame, however many small transport packets that frame carries. All traffic of one source/destination pair travels on a single priority, so the engine sees one ordered stream in each direction.

On the transmit side, each accepted frame descriptor gets the next 8-bit sequence number and is kept in a replay store until the peer acknowledges it. Acknowledgements are cumulative. A negative acknowledgement, or a timer that expires because no progress was acknowledged, rewinds transmission to the oldest frame still held and resends everything from there in order. Too many consecutive rewinds without progress raise a link-failure flag that asks for a reset of this virtual link only. On the receive side, a frame is delivered only if its payload check passed and its sequence number is the one expected next. Every other frame is dropped and answered with a negative acknowledgement.

Top module: `gbn_retry_engine`

## Requirements
- R1: Accepted frames take consecutive sequence numbers starting at 0 after reset and wrapping from 255 to 0. They leave on the MAC port in acceptance order, with the number on `mac_seq_o` and the descriptor on `mac_data_o`, held until `mac_ready_i` is seen high.
- R2: At most WIN (default 16) frames are outstanding (accepted but not yet acknowledged). With WIN outstanding, `tx_ready_o` is low and `tx_valid_i` is ignored.
- R3: An acknowledgement carrying sequence N, with N one of the outstanding numbers under modulo-256 distance from the oldest, frees every outstanding frame up to and including N. An acknowledgement naming no outstanding frame has no effect.
- R4: A negative acknowledgement, while frames are outstanding, makes the next frame offered on the MAC port the oldest unacknowledged one. The following frames are resent after it in their original order with the same descriptors.
- R5: While frames are outstanding, a timer counts clock cycles. It restarts on every valid acknowledgement and every rewind. When it reaches `timeout_i`, transmission rewinds as in R4.
- R6: Each rewind adds one to a retry count, and a valid acknowledgement clears that count. A rewind request that arrives while the count equals `retry_limit_i` sets `link_fail_o` instead. `link_fail_o` stays set until reset. While it is set, `mac_valid_o` and `tx_ready_o` are low.
- R7: The receiver expects sequence 0 after reset. A received frame with `rx_crc_ok_i` high and the expected number is delivered one cycle later on `deliver_valid_o`/`deliver_data_o`, with `rx_ack_o` pulsed and `rx_ack_seq_o` equal to its number. The expected number then advances by one, modulo 256.
- R8: A received frame that fails its payload check, or that carries any number other than the expected one, is not delivered. It produces a one-cycle `rx_nak_o` pulse one cycle later and leaves the expected number unchanged.
- R9: After reset `tx_ready_o` is high, and `mac_valid_o`, `link_fail_o`, `deliver_valid_o`, `rx_ack_o` and `rx_nak_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| timeout_i | input | 16 | Replay timeout in cycles (at least 1) |
| retry_limit_i | input | 4 | Rewinds allowed without progress |
| tx_valid_i | input | 1 | New frame descriptor offered |
| tx_data_i | input | 32 | New frame descriptor |
| tx_ready_o | output | 1 | Descriptor accepted this cycle if valid |
| mac_valid_o | output | 1 | Frame offered to the MAC |
| mac_ready_i | input | 1 | MAC takes the offered frame |
| mac_seq_o | output | 8 | Sequence number of offered frame |
| mac_data_o | output | 32 | Descriptor of offered frame |
| ack_valid_i | input | 1 | Cumulative acknowledgement received |
| ack_seq_i | input | 8 | Highest sequence acknowledged |
| nak_valid_i | input | 1 | Negative acknowledgement received |
| link_fail_o | output | 1 | Retry limit exceeded; reset of this link requested |
| rx_valid_i | input | 1 | Received frame present |
| rx_seq_i | input | 8 | Sequence number of received frame |
| rx_data_i | input | 32 | Received frame descriptor |
| rx_crc_ok_i | input | 1 | Payload check of received frame passed |
| deliver_valid_o | output | 1 | In-order frame delivered |
| deliver_data_o | output | 32 | Delivered descriptor |
| rx_ack_o | output | 1 | Request to acknowledge a delivered frame |
| rx_ack_seq_o | output | 8 | Sequence to acknowledge |
| rx_nak_o | output | 1 | Request to send a negative acknowledgement |

## Verification
The properties assume that `timeout_i` is nonzero and that acknowledgements come from the peer's receiver, so they only name frames that were actually sent. The rewind property also assumes that no acknowledgement arrives in the same cycle as a negative acknowledgement. The stimulus acknowledges only numbers it has seen leave on the MAC port. The one deliberately stale acknowledgement falls outside the outstanding range and must be ignored. Negative acknowledgements are always driven alone, and each scenario sets the timeout long enough that timer replays occur only where a test expects them.

// File: rtl/gbn_pkg.sv
package gbn_pkg;
  parameter int unsigned GBN_SEQ_W  = 8;
  parameter int unsigned GBN_WIN    = 16;
  parameter int unsigned GBN_DATA_W = 32;
  parameter int unsigned GBN_TMO_W  = 16;
  parameter int unsigned GBN_RTY_W  = 4;
endpackage

// File: rtl/gbn_replay_buf.sv
module gbn_replay_buf #(
  parameter int unsigned DEPTH  = 16,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  widx_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic [IDX_W-1:0]  ridx_i,
  output logic [DATA_W-1:0] rdata_o
);
  logic [DATA_W-1:0] mem_q [DEPTH];

  // slots are rewritten only after release, so no reset is needed
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[widx_i] <= wdata_i;
  end

  assign rdata_o = mem_q[ridx_i];
endmodule

// File: rtl/gbn_tx_ctrl.sv
module gbn_tx_ctrl #(
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned WIN   = 16,
  parameter int unsigned TMO_W = 16,
  parameter int unsigned RTY_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [TMO_W-1:0] timeout_i,
  input  logic [RTY_W-1:0] retry_limit_i,
  input  logic             tx_valid_i,
  output logic             tx_ready_o,
  output logic             accept_o,
  output logic [SEQ_W-1:0] wr_seq_o,
  output logic             mac_valid_o,
  input  logic             mac_ready_i,
  output logic [SEQ_W-1:0] send_seq_o,
  input  logic             ack_valid_i,
  input  logic [SEQ_W-1:0] ack_seq_i,
  input  logic             nak_valid_i,
  output logic             link_fail_o,
  output logic [SEQ_W-1:0] base_o,
  output logic [SEQ_W-1:0] outst_o
);
  localparam logic [SEQ_W-1:0] WinCnt = SEQ_W'(WIN);

  logic [SEQ_W-1:0] base_q, next_q, send_q;
  logic [TMO_W-1:0] tmr_q;
  logic [RTY_W-1:0] cnt_q;
  logic             fail_q;

  logic [SEQ_W-1:0] outst, ack_d, new_base, outst_new, send_adv, send_n;
  logic             fire, ack_ok, expire, trig;
  logic [RTY_W-1:0] cnt_base;

  assign outst       = next_q - base_q;
  assign tx_ready_o  = (outst != WinCnt) && !fail_q;
  assign accept_o    = tx_valid_i && tx_ready_o;
  assign wr_seq_o    = next_q;
  assign mac_valid_o = (send_q != next_q) && !fail_q;
  assign fire        = mac_valid_o && mac_ready_i;
  assign send_seq_o  = send_q;
  assign link_fail_o = fail_q;
  assign base_o      = base_q;
  assign outst_o     = outst;

  assign ack_d     = ack_seq_i - base_q;
  assign ack_ok    = ack_valid_i && (ack_d < outst) && !fail_q;
  assign new_base  = ack_ok ? ack_seq_i + 1'b1 : base_q;
  assign outst_new = next_q - new_base;
  assign expire    = (outst != '0) && (tmr_q >= timeout_i);
  // an acknowledgement restarts the timer, so it masks a same-cycle expiry
  assign trig      = !fail_q && (outst_new != '0) &&
                     (nak_valid_i || (expire && !ack_ok));
  assign cnt_base  = ack_ok ? '0 : cnt_q;

  always_comb begin
    send_adv = fire ? send_q + 1'b1 : send_q;
    send_n   = send_adv;
    if (ack_ok && ((send_adv - base_q) <= ack_d)) send_n = new_base;
    if (trig) send_n = new_base;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      next_q <= '0;
      send_q <= '0;
      tmr_q  <= '0;
      cnt_q  <= '0;
      fail_q <= 1'b0;
    end else if (!fail_q) begin
      base_q <= new_base;
      send_q <= send_n;
      if (accept_o) next_q <= next_q + 1'b1;
      if (ack_ok || trig || (outst_new == '0)) tmr_q <= '0;
      else if (tmr_q != '1) tmr_q <= tmr_q + 1'b1;
      if (trig && (cnt_base == retry_limit_i)) fail_q <= 1'b1;
      else if (trig) cnt_q <= cnt_base + 1'b1;
      else cnt_q <= cnt_base;
    end
  end
endmodule

// File: rtl/gbn_rx_check.sv
module gbn_rx_check #(
  parameter int unsigned SEQ_W  = 8,
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rx_valid_i,
  input  logic [SEQ_W-1:0]  rx_seq_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_crc_ok_i,
  output logic              deliver_valid_o,
  output logic [DATA_W-1:0] deliver_data_o,
  output logic              rx_ack_o,
  output logic [SEQ_W-1:0]  rx_ack_seq_o,
  output logic              rx_nak_o,
  output logic [SEQ_W-1:0]  expect_o
);
  logic [SEQ_W-1:0] exp_q;
  logic             good;

  assign good     = rx_valid_i && rx_crc_ok_i && (rx_seq_i == exp_q);
  assign expect_o = exp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exp_q           <= '0;
      deliver_valid_o <= 1'b0;
      deliver_data_o  <= '0;
      rx_ack_o        <= 1'b0;
      rx_ack_seq_o    <= '0;
      rx_nak_o        <= 1'b0;
    end else begin
      deliver_valid_o <= good;
      rx_ack_o        <= good;
      rx_nak_o        <= rx_valid_i && !good;
      if (good) begin
        exp_q          <= exp_q + 1'b1;
        deliver_data_o <= rx_data_i;
        rx_ack_seq_o   <= rx_seq_i;
      end
    end
  end
endmodule

// File: rtl/gbn_retry_engine.sv
module gbn_retry_engine
  import gbn_pkg::*;
#(
  parameter int unsigned SEQ_W  = GBN_SEQ_W,
  parameter int unsigned WIN    = GBN_WIN,
  parameter int unsigned DATA_W = GBN_DATA_W,
  parameter int unsigned TMO_W  = GBN_TMO_W,
  parameter int unsigned RTY_W  = GBN_RTY_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [TMO_W-1:0]  timeout_i,
  input  logic [RTY_W-1:0]  retry_limit_i,
  input  logic              tx_valid_i,
  input  logic [DATA_W-1:0] tx_data_i,
  output logic              tx_ready_o,
  output logic              mac_valid_o,
  input  logic              mac_ready_i,
  output logic [SEQ_W-1:0]  mac_seq_o,
  output logic [DATA_W-1:0] mac_data_o,
  input  logic              ack_valid_i,
  input  logic [SEQ_W-1:0]  ack_seq_i,
  input  logic              nak_valid_i,
  output logic              link_fail_o,
  input  logic              rx_valid_i,
  input  logic [SEQ_W-1:0]  rx_seq_i,
  input  logic [DATA_W-1:0] rx_data_i,
  input  logic              rx_crc_ok_i,
  output logic              deliver_valid_o,
  output logic [DATA_W-1:0] deliver_data_o,
  output logic              rx_ack_o,
  output logic [SEQ_W-1:0]  rx_ack_seq_o,
  output logic              rx_nak_o
);
  localparam int unsigned IDX_W = $clog2(WIN);

  logic             accept;
  logic [SEQ_W-1:0] wr_seq, base_seq, outst, rx_expect;

  gbn_tx_ctrl #(.SEQ_W(SEQ_W), .WIN(WIN), .TMO_W(TMO_W), .RTY_W(RTY_W)) u_tx (
    .clk_i, .rst_ni, .timeout_i, .retry_limit_i,
    .tx_valid_i, .tx_ready_o,
    .accept_o    (accept),
    .wr_seq_o    (wr_seq),
    .mac_valid_o, .mac_ready_i,
    .send_seq_o  (mac_seq_o),
    .ack_valid_i, .ack_seq_i, .nak_valid_i, .link_fail_o,
    .base_o      (base_seq),
    .outst_o     (outst)
  );

  gbn_replay_buf #(.DEPTH(WIN), .DATA_W(DATA_W)) u_buf (
    .clk_i,
    .we_i    (accept),
    .widx_i  (wr_seq[IDX_W-1:0]),
    .wdata_i (tx_data_i),
    .ridx_i  (mac_seq_o[IDX_W-1:0]),
    .rdata_o (mac_data_o)
  );

  gbn_rx_check #(.SEQ_W(SEQ_W), .DATA_W(DATA_W)) u_rx (
    .clk_i, .rst_ni, .rx_valid_i, .rx_seq_i, .rx_data_i, .rx_crc_ok_i,
    .deliver_valid_o, .deliver_data_o, .rx_ack_o, .rx_ack_seq_o, .rx_nak_o,
    .expect_o (rx_expect)
  );
endmodule

// File: rtl/gbn_retry_engine_chk.sv
module gbn_retry_engine_chk #(
  parameter int unsigned SEQ_W = 8,
  parameter int unsigned WIN   = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             tx_ready_o,
  input logic             mac_valid_o,
  input logic [SEQ_W-1:0] mac_seq_o,
  input logic             ack_valid_i,
  input logic [SEQ_W-1:0] ack_seq_i,
  input logic             nak_valid_i,
  input logic             link_fail_o,
  input logic             rx_valid_i,
  input logic [SEQ_W-1:0] rx_seq_i,
  input logic             rx_crc_ok_i,
  input logic             deliver_valid_o,
  input logic             rx_ack_o,
  input logic             rx_nak_o,
  input logic [SEQ_W-1:0] base_seq,
  input logic [SEQ_W-1:0] outst,
  input logic [SEQ_W-1:0] rx_expect
);
  a_r2_window_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
    outst <= SEQ_W'(WIN));

  a_r2_full_stall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (outst == SEQ_W'(WIN)) |-> !tx_ready_o);

  a_r3_ack_frees: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_valid_i && !link_fail_o && ((ack_seq_i - base_seq) < outst))
      |=> (base_seq == $past(ack_seq_i) + 1'b1));

  a_r4_nak_rewind: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (nak_valid_i && !ack_valid_i && !link_fail_o && (outst != '0))
      |=> (link_fail_o || (mac_seq_o == $past(base_seq))));

  a_r6_fail_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_fail_o |=> link_fail_o);

  a_r6_fail_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    link_fail_o |-> (!mac_valid_o && !tx_ready_o));

  a_r7_in_order_accept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && rx_crc_ok_i && (rx_seq_i == rx_expect))
      |=> (deliver_valid_o && rx_ack_o && !rx_nak_o));

  a_r8_discard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_i && !(rx_crc_ok_i && (rx_seq_i == rx_expect)))
      |=> (!deliver_valid_o && rx_nak_o && $stable(rx_expect)));
endmodule

bind gbn_retry_engine gbn_retry_engine_chk #(.SEQ_W(SEQ_W), .WIN(WIN)) u_chk (
  .clk_i, .rst_ni, .tx_ready_o, .mac_valid_o, .mac_seq_o,
  .ack_valid_i, .ack_seq_i, .nak_valid_i, .link_fail_o,
  .rx_valid_i, .rx_seq_i, .rx_crc_ok_i,
  .deliver_valid_o, .rx_ack_o, .rx_nak_o,
  .base_seq, .outst, .rx_expect
);

// File: tb/test_gbn_retry_engine.sv
module test_gbn_retry_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] timeout = 16'd1000;
  logic [3:0]  rlimit = 4'd2;
  logic        tx_valid = 1'b0;
  logic [31:0] tx_data = '0;
  logic        tx_ready;
  logic        mac_valid;
  logic        mac_ready = 1'b0;
  logic [7:0]  mac_seq;
  logic [31:0] mac_data;
  logic        ack_valid = 1'b0;
  logic [7:0]  ack_seq = '0;
  logic        nak_valid = 1'b0;
  logic        link_fail;
  logic        rx_valid = 1'b0;
  logic [7:0]  rx_seq = '0;
  logic [31:0] rx_data = '0;
  logic        rx_crc_ok = 1'b0;
  logic        deliver_valid;
  logic [31:0] deliver_data;
  logic        rx_ack;
  logic [7:0]  rx_ack_seq;
  logic        rx_nak;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  gbn_retry_engine i_gbn_retry_engine (
    .clk_i(clk), .rst_ni(rst_n), .timeout_i(timeout), .retry_limit_i(rlimit),
    .tx_valid_i(tx_valid), .tx_data_i(tx_data), .tx_ready_o(tx_ready),
    .mac_valid_o(mac_valid), .mac_ready_i(mac_ready), .mac_seq_o(mac_seq),
    .mac_data_o(mac_data), .ack_valid_i(ack_valid), .ack_seq_i(ack_seq),
    .nak_valid_i(nak_valid), .link_fail_o(link_fail),
    .rx_valid_i(rx_valid), .rx_seq_i(rx_seq), .rx_data_i(rx_data),
    .rx_crc_ok_i(rx_crc_ok), .deliver_valid_o(deliver_valid),
    .deliver_data_o(deliver_data), .rx_ack_o(rx_ack),
    .rx_ack_seq_o(rx_ack_seq), .rx_nak_o(rx_nak)
  );

  // receive vectors: [9:2] sequence, [1] payload check ok, [0] delivery expected
  localparam int NRX = 12;
  localparam logic [9:0] RX_TAB [NRX] = '{
    {8'd0, 1'b1, 1'b1}, {8'd1, 1'b1, 1'b1}, {8'd3, 1'b1, 1'b0},
    {8'd2, 1'b0, 1'b0}, {8'd2, 1'b1, 1'b1}, {8'd2, 1'b1, 1'b0},
    {8'd3, 1'b1, 1'b1}, {8'd4, 1'b0, 1'b0}, {8'd4, 1'b1, 1'b1},
    {8'd9, 1'b1, 1'b0}, {8'd5, 1'b1, 1'b1}, {8'd6, 1'b1, 1'b1}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_ack(input logic [7:0] s);
    ack_valid = 1'b1; ack_seq = s;
    step();
    ack_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int waited;
    bit seen;
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(tx_ready == 1'b1, "R9 tx_ready", tx_ready, 1);
    chk(!mac_valid && !link_fail, "R9 mac_valid/link_fail", {mac_valid, link_fail}, 0);
    chk(!deliver_valid && !rx_ack && !rx_nak, "R9 rx outputs", {deliver_valid, rx_ack, rx_nak}, 0);
    rst_n = 1'b1;
    step();

    // R7 R8 table of receive vectors
    for (int i = 0; i < NRX; i++) begin
      rx_valid = 1'b1;
      rx_seq = RX_TAB[i][9:2];
      rx_crc_ok = RX_TAB[i][1];
      rx_data = 32'(RX_TAB[i][9:2]) * 3 + 7;
      step();
      rx_valid = 1'b0;
      if (RX_TAB[i][0]) begin
        chk(deliver_valid && rx_ack && !rx_nak, "R7 delivered", {deliver_valid, rx_ack, rx_nak}, 6);
        chk(rx_ack_seq == RX_TAB[i][9:2], "R7 ack seq", rx_ack_seq, RX_TAB[i][9:2]);
        chk(deliver_data == 32'(RX_TAB[i][9:2]) * 3 + 7, "R7 data", deliver_data, 32'(RX_TAB[i][9:2]) * 3 + 7);
      end else begin
        chk(!deliver_valid && !rx_ack && rx_nak, "R8 discarded", {deliver_valid, rx_ack, rx_nak}, 1);
      end
    end
    step();
    chk(!rx_nak && !deliver_valid, "R8 nak one cycle", {rx_nak, deliver_valid}, 0);

    // R2 fill the window while the MAC stalls
    for (int i = 0; i < 16; i++) begin
      tx_valid = 1'b1; tx_data = 32'(100 + i);
      step();
    end
    chk(tx_ready == 1'b0, "R2 full stall", tx_ready, 0);
    tx_data = 32'd999;
    step(); // offered while full, must be dropped
    tx_valid = 1'b0;
    chk(mac_valid && mac_seq == 8'd0 && mac_data == 32'd100, "R1 hold while stalled", mac_seq, 0);

    // R1 drain in order
    mac_ready = 1'b1;
    for (int i = 0; i < 16; i++) begin
      chk(mac_valid && mac_seq == 8'(i) && mac_data == 32'(100 + i), "R1 order", mac_seq, i);
      step();
    end
    chk(!mac_valid, "R2 extra frame dropped", mac_valid, 0);

    // R3 cumulative ack, then stale ack ignored
    send_ack(8'd4);
    chk(tx_ready == 1'b1, "R3 ack frees window", tx_ready, 1);
    send_ack(8'd200);
    // R4 rewind goes to oldest unacked (5), proving the stale ack had no effect
    nak_valid = 1'b1;
    step();
    nak_valid = 1'b0;
    for (int i = 5; i < 16; i++) begin
      chk(mac_valid && mac_seq == 8'(i) && mac_data == 32'(100 + i), "R4 replay order", mac_seq, i);
      step();
    end
    chk(!mac_valid, "R4 replay ends", mac_valid, 0);
    send_ack(8'd15);
    chk(tx_ready && !mac_valid, "R3 all freed", {tx_ready, mac_valid}, 2);

    // R5 timeout replay
    timeout = 16'd20;
    tx_valid = 1'b1; tx_data = 32'd300;
    step();
    tx_valid = 1'b0;
    chk(mac_valid && mac_seq == 8'd16, "R1 seq continues", mac_seq, 16);
    step();
    waited = 0; seen = 1'b0;
    while (waited < 60 && !seen) begin
      if (mac_valid) seen = 1'b1;
      else begin step(); waited++; end
    end
    chk(seen && waited >= 15 && waited <= 25, "R5 timeout delay", waited, 20);
    chk(mac_seq == 8'd16 && mac_data == 32'd300, "R5 replay frame", mac_seq, 16);

    // R6 retry limit
    waited = 0;
    while (waited < 300 && !link_fail) begin step(); waited++; end
    chk(link_fail == 1'b1, "R6 link fail", link_fail, 1);
    chk(!mac_valid && !tx_ready, "R6 quiet on fail", {mac_valid, tx_ready}, 0);
    send_ack(8'd16);
    chk(link_fail == 1'b1, "R6 sticky", link_fail, 1);
    rst_n = 1'b0;
    step();
    rst_n = 1'b1;
    step();
    chk(!link_fail && tx_ready, "R6 cleared by reset", {link_fail, tx_ready}, 1);

    // R1 R3 sequence wrap with cumulative ack of each frame
    timeout = 16'd1000;
    for (int i = 0; i < 300; i++) begin
      tx_valid = 1'b1; tx_data = 32'(5000 + i);
      step();
      tx_valid = 1'b0;
      chk(mac_valid && mac_seq == 8'(i) && mac_data == 32'(5000 + i), "R1 wrap seq", mac_seq, i % 256);
      step();
      send_ack(8'(i));
    end
    chk(!mac_valid && tx_ready, "R3 idle after wrap", {mac_valid, tx_ready}, 1);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule